// File: doc/BRIEF.md
# Trap Entry Sequencer

This block steers the processor from the moment a trap condition is reported until a new set of status words is in place. The execution unit raises one request bit per trap condition, each with a two-bit timing class. The sequencer picks one request, latches it, and freezes the program counter. It then tells the execution unit how to end the current instruction: abort it, stop at the next iteration boundary of a long string operation, or let it finish.

Once the instruction has ended, the sequencer requests a fetch from the trap's own vector address, which is a base value plus the trap index. It then checks that the fetched opcode is one of the two status-exchange opcodes. Any other opcode starts a second entry, this time to the instruction-exception vector. If that second fetch also fails, the sequencer halts. Interrupt acknowledgement is withheld for the whole sequence and released when the status exchange reports completion.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `pc_hold_o`, `irq_inhibit_o`, `fetch_req_o`, `halt_o` and `done_o` are low.
- R2: A request seen while idle sets the trap state. From the next cycle until completion, `pc_hold_o` and `irq_inhibit_o` are high.
- R3: While `fetch_req_o` is high, `vec_addr_o` equals VEC_BASE (default 0x40) plus the index of the selected trap.
- R4: Among simultaneous requests, the lowest index wins. Requests that arrive during a sequence do not change the selected index or vector.
- R5: Class 0 (abort) drives `fetch_req_o` and `abort_o` high in the cycle after detection.
- R6: Class 1 (iteration boundary) drives `drain_o` high. It holds off the fetch until `iter_done_i` or `instr_done_i` is seen.
- R7: Classes 2 and 3 (completion) wait for `instr_done_i` only, ignoring `iter_done_i`, and `mode_o` reports 2.
- R8: A fetched opcode is accepted only if it equals OP_XCHG_A (0x0F) or OP_XCHG_B (0x0A). Any other opcode makes the next cycle request a fetch from VEC_BASE + IEXC_IDX (default 7), still in the trap state.
- R9: If the instruction-exception fetch is also rejected, `halt_o` goes high and stays high until reset, with no further fetch requests and no new entries.
- R10: `irq_ack_o` follows `irq_ready_i` while `irq_inhibit_o` is low, and is low whenever `irq_inhibit_o` is high.
- R11: `xchg_done_i` during the exchange pulses `done_o` for exactly one cycle on the next cycle, and the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trap_req_i | input | N_TRAPS | One request bit per trap condition |
| trap_cls_i | input | 2*N_TRAPS | Timing class per trap, two bits each, trap i at [2i+1:2i] |
| iter_done_i | input | 1 | Current instruction reached an iteration boundary |
| instr_done_i | input | 1 | Current instruction completed |
| fetch_op_i | input | OP_W | Opcode fetched from the trap vector |
| fetch_valid_i | input | 1 | Fetched opcode is valid this cycle |
| xchg_done_i | input | 1 | New status words have replaced the old ones |
| irq_ready_i | input | 1 | An interrupt level is ready to become active |
| fetch_req_o | output | 1 | Request a fetch from `vec_addr_o` |
| vec_addr_o | output | ADDR_W | Trap vector address |
| pc_hold_o | output | 1 | Program counter must not advance |
| abort_o | output | 1 | Abort the current instruction |
| drain_o | output | 1 | Run the current instruction to its stop point |
| mode_o | output | 2 | Latched timing class (3 reported as 2) |
| irq_inhibit_o | output | 1 | Interrupt acknowledgement blocked |
| irq_ack_o | output | 1 | Interrupt acknowledge |
| done_o | output | 1 | Trap entry finished (one-cycle pulse) |
| halt_o | output | 1 | Unrecoverable double instruction-exception |

## Verification
The assertions assume the execution unit raises `iter_done_i` and `instr_done_i` only while the sequencer is waiting. They also assume `fetch_valid_i` comes only in answer to a fetch request, and `xchg_done_i` only during the exchange. The stimulus follows these rules: it raises each handshake input for a single cycle, and only after observing the state that calls for it. The one exception is the R6/R7 checks, which deliberately present the input that must be ignored. It also raises extra trap requests mid-sequence and after a halt, to show that they are not taken.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_FETCH, S_XCHG, S_HALT
  } tseq_state_e;

  typedef enum logic [1:0] {
    CLS_ABORT = 2'd0,
    CLS_ITER  = 2'd1,
    CLS_DONE  = 2'd2,
    CLS_RSV   = 2'd3
  } tclass_e;
endpackage

// File: rtl/trap_pick.sv
module trap_pick #(
  parameter int N_TRAPS = 8,
  localparam int IDX_W = $clog2(N_TRAPS)
) (
  input  logic [N_TRAPS-1:0]   req_i,
  input  logic [2*N_TRAPS-1:0] cls_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [1:0]           cls_o
);
  logic [N_TRAPS-1:0] first;

  for (genvar g = 0; g < N_TRAPS; g++) begin : g_first
    if (g == 0) begin : g_lo
      assign first[g] = req_i[0];
    end else begin : g_hi
      assign first[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    cls_o = '0;
    for (int i = 0; i < N_TRAPS; i++) begin
      if (first[i]) begin
        idx_o = idx_o | IDX_W'(i);
        cls_o = cls_o | cls_i[2*i +: 2];
      end
    end
  end
endmodule

// File: rtl/trap_opchk.sv
module trap_opchk #(
  parameter int OP_W = 8,
  parameter logic [OP_W-1:0] OP_XCHG_A = 8'h0F,
  parameter logic [OP_W-1:0] OP_XCHG_B = 8'h0A
) (
  input  logic [OP_W-1:0] op_i,
  output logic            ok_o
);
  assign ok_o = (op_i == OP_XCHG_A) || (op_i == OP_XCHG_B);
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
  import trap_pkg::*;
#(
  parameter int N_TRAPS  = 8,
  parameter int IEXC_IDX = N_TRAPS - 1,
  localparam int IDX_W = $clog2(N_TRAPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             any_req_i,
  input  logic [IDX_W-1:0] pick_idx_i,
  input  logic [1:0]       pick_cls_i,
  input  logic             iter_done_i,
  input  logic             instr_done_i,
  input  logic             fetch_valid_i,
  input  logic             op_ok_i,
  input  logic             xchg_done_i,
  output logic [IDX_W-1:0] idx_o,
  output logic [1:0]       mode_o,
  output logic             fetch_req_o,
  output logic             pc_hold_o,
  output logic             irq_inhibit_o,
  output logic             abort_o,
  output logic             drain_o,
  output logic             halt_o,
  output logic             done_o
);
  tseq_state_e      state_q;
  tclass_e          cls_q, cls_n;
  logic [IDX_W-1:0] idx_q;
  logic             retried_q, done_q;

  assign cls_n = (tclass_e'(pick_cls_i) == CLS_RSV) ? CLS_DONE : tclass_e'(pick_cls_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      cls_q     <= CLS_ABORT;
      idx_q     <= '0;
      retried_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (any_req_i) begin
          idx_q     <= pick_idx_i;
          cls_q     <= cls_n;
          retried_q <= 1'b0;
          state_q   <= (cls_n == CLS_ABORT) ? S_FETCH : S_WAIT;
        end
        S_WAIT: if (instr_done_i || (cls_q == CLS_ITER && iter_done_i)) state_q <= S_FETCH;
        S_FETCH: if (fetch_valid_i) begin
          if (op_ok_i) state_q <= S_XCHG;
          else if (!retried_q) begin
            idx_q     <= IDX_W'(IEXC_IDX);
            retried_q <= 1'b1;
          end else state_q <= S_HALT;
        end
        S_XCHG: if (xchg_done_i) begin
          state_q <= S_IDLE;
          done_q  <= 1'b1;
        end
        S_HALT: state_q <= S_HALT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign idx_o         = idx_q;
  assign mode_o        = cls_q;
  assign fetch_req_o   = (state_q == S_FETCH);
  assign pc_hold_o     = (state_q != S_IDLE);
  assign irq_inhibit_o = (state_q != S_IDLE);
  assign abort_o       = (state_q == S_FETCH) && (cls_q == CLS_ABORT) && !retried_q;
  assign drain_o       = (state_q == S_WAIT);
  assign halt_o        = (state_q == S_HALT);
  assign done_o        = done_q;

  AST_ENTRY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && any_req_i) |=> (pc_hold_o && irq_inhibit_o)); // R2
  AST_IDX_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT || state_q == S_XCHG) |=> $stable(idx_q)); // R4
  AST_ABORT_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && any_req_i && pick_cls_i == 2'd0) |=> (fetch_req_o && abort_o)); // R5
  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && !instr_done_i && !iter_done_i) |=> drain_o); // R6
  AST_DONE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && cls_q == CLS_DONE && !instr_done_i) |=> !fetch_req_o); // R7
  AST_IEXC_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && fetch_valid_i && !op_ok_i && !retried_q)
      |=> (fetch_req_o && idx_q == IDX_W'(IEXC_IDX))); // R8
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (halt_o && !fetch_req_o)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq #(
  parameter int N_TRAPS  = 8,
  parameter int ADDR_W   = 16,
  parameter int OP_W     = 8,
  parameter int VEC_BASE = 'h40,
  parameter int IEXC_IDX = N_TRAPS - 1,
  parameter logic [OP_W-1:0] OP_XCHG_A = 8'h0F,
  parameter logic [OP_W-1:0] OP_XCHG_B = 8'h0A,
  localparam int IDX_W = $clog2(N_TRAPS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_TRAPS-1:0]   trap_req_i,
  input  logic [2*N_TRAPS-1:0] trap_cls_i,
  input  logic                 iter_done_i,
  input  logic                 instr_done_i,
  input  logic [OP_W-1:0]      fetch_op_i,
  input  logic                 fetch_valid_i,
  input  logic                 xchg_done_i,
  input  logic                 irq_ready_i,
  output logic                 fetch_req_o,
  output logic [ADDR_W-1:0]    vec_addr_o,
  output logic                 pc_hold_o,
  output logic                 abort_o,
  output logic                 drain_o,
  output logic [1:0]           mode_o,
  output logic                 irq_inhibit_o,
  output logic                 irq_ack_o,
  output logic                 done_o,
  output logic                 halt_o
);
  logic             any_req, op_ok;
  logic [IDX_W-1:0] pick_idx, idx;
  logic [1:0]       pick_cls;

  trap_pick #(.N_TRAPS(N_TRAPS)) u_pick (
    .req_i (trap_req_i),
    .cls_i (trap_cls_i),
    .any_o (any_req),
    .idx_o (pick_idx),
    .cls_o (pick_cls)
  );

  trap_opchk #(.OP_W(OP_W), .OP_XCHG_A(OP_XCHG_A), .OP_XCHG_B(OP_XCHG_B)) u_opchk (
    .op_i (fetch_op_i),
    .ok_o (op_ok)
  );

  trap_fsm #(.N_TRAPS(N_TRAPS), .IEXC_IDX(IEXC_IDX)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .any_req_i     (any_req),
    .pick_idx_i    (pick_idx),
    .pick_cls_i    (pick_cls),
    .iter_done_i   (iter_done_i),
    .instr_done_i  (instr_done_i),
    .fetch_valid_i (fetch_valid_i),
    .op_ok_i       (op_ok),
    .xchg_done_i   (xchg_done_i),
    .idx_o         (idx),
    .mode_o        (mode_o),
    .fetch_req_o   (fetch_req_o),
    .pc_hold_o     (pc_hold_o),
    .irq_inhibit_o (irq_inhibit_o),
    .abort_o       (abort_o),
    .drain_o       (drain_o),
    .halt_o        (halt_o),
    .done_o        (done_o)
  );

  assign vec_addr_o = ADDR_W'(VEC_BASE) + ADDR_W'(idx);
  assign irq_ack_o  = irq_ready_i && !irq_inhibit_o;

  AST_VEC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |-> ((vec_addr_o - ADDR_W'(VEC_BASE)) < ADDR_W'(N_TRAPS))); // R3
  AST_NO_ACK_IN_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_hold_o |-> !irq_ack_o); // R10
endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;
  localparam int BASE = 'h40;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  trap_req = '0;
  logic [15:0] trap_cls = '0;
  logic        iter_done = 0, instr_done = 0, fetch_valid = 0, xchg_done = 0, irq_ready = 0;
  logic [7:0]  fetch_op = '0;
  logic        fetch_req, pc_hold, abort, drain, irq_inhibit, irq_ack, done, halt;
  logic [15:0] vec_addr;
  logic [1:0]  mode;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];

  always #10 clk = ~clk;

  trap_entry_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .trap_req_i(trap_req), .trap_cls_i(trap_cls),
    .iter_done_i(iter_done), .instr_done_i(instr_done), .fetch_op_i(fetch_op),
    .fetch_valid_i(fetch_valid), .xchg_done_i(xchg_done), .irq_ready_i(irq_ready),
    .fetch_req_o(fetch_req), .vec_addr_o(vec_addr), .pc_hold_o(pc_hold),
    .abort_o(abort), .drain_o(drain), .mode_o(mode), .irq_inhibit_o(irq_inhibit),
    .irq_ack_o(irq_ack), .done_o(done), .halt_o(halt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic run_fetch(input logic [7:0] op);
    fetch_valid = 1'b1;
    fetch_op    = op;
    tick();
    fetch_valid = 1'b0;
  endtask

  task automatic finish_xchg();
    xchg_done = 1'b1;
    tick();
    xchg_done = 1'b0;
    chk("R11 done pulse", done, 1);
    chk("R11 back to idle", pc_hold, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: each accepted fetch is compared with the next expected vector
  always @(negedge clk) begin
    if (rst_ni && fetch_req && fetch_valid) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3 unexpected fetch act=%0h exp=none", vec_addr);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (vec_addr !== 16'(e)) begin
          n_fail++;
          $display("FAIL R3 vector act=%0h exp=%0h", vec_addr, e);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=finished");
    report();
  end

  initial begin
    tick();
    tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    chk("R1 pc_hold", pc_hold, 0);
    chk("R1 inhibit", irq_inhibit, 0);
    chk("R1 fetch_req", fetch_req, 0);
    chk("R1 halt", halt, 0);
    chk("R1 done", done, 0);
    irq_ready = 1'b1; #1;
    chk("R10 ack when idle", irq_ack, 1);
    irq_ready = 1'b0;

    // abort class, index 3
    exp_q.push_back(BASE + 3);
    trap_req = 8'h08; trap_cls = '0;
    tick();
    trap_req = '0;
    chk("R5 fetch at once", fetch_req, 1);
    chk("R5 abort", abort, 1);
    chk("R2 pc_hold", pc_hold, 1);
    chk("R3 vector", vec_addr, BASE + 3);
    irq_ready = 1'b1; #1;
    chk("R10 ack blocked", irq_ack, 0);
    run_fetch(8'h0F);
    chk("R2 hold in exchange", pc_hold, 1);
    chk("R10 blocked in exchange", irq_ack, 0);
    finish_xchg();
    chk("R10 ack released", irq_ack, 1);
    tick();
    chk("R11 single pulse", done, 0);
    irq_ready = 1'b0;

    // priority among simultaneous requests
    exp_q.push_back(BASE + 2);
    trap_req = 8'b0110_0100;
    tick();
    trap_req = '0;
    chk("R4 lowest wins", vec_addr, BASE + 2);
    run_fetch(8'h0A);
    finish_xchg();

    // iteration class, index 1; higher priority arrives mid-sequence
    exp_q.push_back(BASE + 1);
    trap_req = 8'h02; trap_cls = 16'h0004;
    tick();
    chk("R6 drain", drain, 1);
    chk("R6 no fetch yet", fetch_req, 0);
    chk("R6 mode", mode, 1);
    trap_req = 8'h01;
    tick();
    chk("R6 still waiting", drain, 1);
    iter_done = 1'b1;
    tick();
    iter_done = 1'b0; trap_req = '0;
    chk("R6 fetch after boundary", fetch_req, 1);
    chk("R4 index kept", vec_addr, BASE + 1);
    chk("R6 no abort", abort, 0);
    run_fetch(8'h0F);
    finish_xchg();

    // completion class, index 4
    exp_q.push_back(BASE + 4);
    trap_req = 8'h10; trap_cls = 16'h0200;
    tick();
    trap_req = '0;
    chk("R7 mode", mode, 2);
    iter_done = 1'b1;
    tick();
    iter_done = 1'b0;
    chk("R7 boundary ignored", fetch_req, 0);
    chk("R7 still draining", drain, 1);
    instr_done = 1'b1;
    tick();
    instr_done = 1'b0;
    chk("R7 fetch after completion", fetch_req, 1);
    run_fetch(8'h0A);
    finish_xchg();

    // reserved class 3 behaves as completion, index 5
    exp_q.push_back(BASE + 5);
    trap_req = 8'h20; trap_cls = 16'h0C00;
    tick();
    trap_req = '0;
    chk("R7 class3 mode", mode, 2);
    chk("R7 class3 waits", fetch_req, 0);
    instr_done = 1'b1;
    tick();
    instr_done = 1'b0;
    run_fetch(8'h0F);
    finish_xchg();

    // bad opcode then recovered at exception vector
    exp_q.push_back(BASE + 0);
    exp_q.push_back(BASE + 7);
    trap_req = 8'h01; trap_cls = '0;
    tick();
    trap_req = '0;
    run_fetch(8'h22);
    chk("R8 refetch", fetch_req, 1);
    chk("R8 exception vector", vec_addr, BASE + 7);
    chk("R8 still held", pc_hold, 1);
    chk("R8 no halt", halt, 0);
    run_fetch(8'h0A);
    finish_xchg();

    // double failure halts
    exp_q.push_back(BASE + 6);
    exp_q.push_back(BASE + 7);
    trap_req = 8'h40;
    tick();
    trap_req = '0;
    run_fetch(8'h22);
    run_fetch(8'h33);
    chk("R9 halt", halt, 1);
    chk("R9 no fetch", fetch_req, 0);
    trap_req = 8'h01;
    tick();
    tick();
    chk("R9 halt sticky", halt, 1);
    chk("R9 new trap ignored", fetch_req, 0);
    chk("R9 inhibit held", irq_inhibit, 1);
    irq_ready = 1'b1; #1;
    chk("R10 ack blocked in halt", irq_ack, 0);
    trap_req = '0; irq_ready = 1'b0;

    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 halt cleared", halt, 0);
    chk("R1 pc_hold cleared", pc_hold, 0);
    chk("R3 all fetches seen", exp_q.size(), 0);

    report();
  end
endmodule